// File: doc/BRIEF.md
# AHB Wait-State Contract Monitor

This block is a passive observer placed on one AHB link between a manager and the interconnect. It drives nothing on the bus. It watches the transfer type, address, control, write data, ready, response and per-subordinate select lines. It also watches two further signals. The first is the one-hot select that the interconnect uses for its response mux. The second is the manager's read-capture strobe. From these it detects the five ways the wait-state contract is commonly broken.

The five failures are: address or control moving during a wait, write data moving during a wait, read data captured before the subordinate is ready, a stall that never ends, and a response paired with the wrong subordinate. Each failure sets its own sticky bit in `err_o`, and the bits stay set until `clear_i` is asserted. `err_pulse_o` flags the first cycle of any violation whose bit was not already set. A manager with no capture strobe to expose ties `rd_capture_i` low.

Top module: `ahb_wait_monitor`

## Requirements
- R1: Bit 0 of `err_o` is set when, in the cycle after one in which HREADY was low and HTRANS was NONSEQ (2'b10) or SEQ (2'b11), any of HTRANS, HADDR, HWRITE, HSIZE or HBURST differs from its value in that wait cycle.
- R2: The R1 check is skipped in the cycle after a wait cycle in which `hresp_i` was 1 (ERROR), so the manager may cancel to IDLE in the second cycle of an error response.
- R3: Bit 1 of `err_o` is set when HWDATA changes between a write data-phase cycle with HREADY low and the following cycle. Changes during a read data phase are ignored.
- R4: Bit 2 of `err_o` is set when `rd_capture_i` is high in a read data-phase cycle while HREADY is low. A capture with HREADY high, or outside a read data phase, is not flagged.
- R5: Bit 3 of `err_o` is set when HREADY stays low for more than HANG_LIMIT consecutive cycles. A run of exactly HANG_LIMIT cycles is not flagged, and any cycle with HREADY high restarts the count.
- R6: Bit 4 of `err_o` is set when a data phase completes (HREADY high) while `resp_sel_i` differs from the HSEL value captured when that transfer's address phase was accepted. The check is made only on the completing cycle.
- R7: After reset, no rule is checked, and the stall count stays at zero, until one cycle with HREADY high has been seen.
- R8: Bits of `err_o` are sticky, and only a synchronous `clear_i` returns them all to zero on the next edge. Clear takes priority over a violation in the same cycle.
- R9: `err_pulse_o` is high, combinationally, in exactly the cycles in which a rule is violated whose bit in `err_o` is still clear. A repeat of an already flagged rule produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of all error bits |
| htrans_i | input | 2 | Transfer type (IDLE 00, BUSY 01, NONSEQ 10, SEQ 11) |
| haddr_i | input | AW | Address |
| hwrite_i | input | 1 | Write direction |
| hsize_i | input | 3 | Transfer size |
| hburst_i | input | 3 | Burst type |
| hwdata_i | input | DW | Write data |
| hready_i | input | 1 | Bus ready seen by the manager |
| hresp_i | input | 1 | Response, 1 means ERROR |
| hsel_i | input | NSUB | Per-subordinate address-phase select |
| resp_sel_i | input | NSUB | One-hot select driving the response mux |
| rd_capture_i | input | 1 | Manager read-data capture enable |
| err_o | output | 5 | Sticky per-rule error bits |
| err_pulse_o | output | 1 | High on the first cycle of a new violation |

## Verification
The bench builds the monitor with an 8-bit address, 8-bit write data, four subordinates and a hang limit of 8. With those sizes it can flip every address bit, every write-data bit and each control field one at a time during a held wait. It can also try all sixteen pairings of captured select against response select. The stall sweep runs past the hang limit and covers the lengths on both sides of it. The early-sample rule is swept over every combination of ready level, phase kind and strobe level.

// File: rtl/wm_pkg.sv
package wm_pkg;
  localparam int unsigned RULE_HOLD  = 0;
  localparam int unsigned RULE_WDATA = 1;
  localparam int unsigned RULE_EARLY = 2;
  localparam int unsigned RULE_HANG  = 3;
  localparam int unsigned RULE_SEL   = 4;
  localparam int unsigned NUM_RULES  = 5;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;
endpackage

// File: rtl/wm_pipe.sv
module wm_pipe #(
  parameter int unsigned NSUB = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hready_i,
  input  logic [1:0]      htrans_i,
  input  logic            hwrite_i,
  input  logic [NSUB-1:0] hsel_i,
  output logic            seen_o,
  output logic            addr_act_o,
  output logic            dp_valid_o,
  output logic            dp_write_o,
  output logic [NSUB-1:0] dp_sel_o
);
  import wm_pkg::*;

  trans_e trans;
  assign trans      = trans_e'(htrans_i);
  assign addr_act_o = (trans == TR_NONSEQ) || (trans == TR_SEQ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_o     <= 1'b0;
      dp_valid_o <= 1'b0;
      dp_write_o <= 1'b0;
      dp_sel_o   <= '0;
    end else if (hready_i) begin
      seen_o     <= 1'b1;
      dp_valid_o <= addr_act_o;
      if (addr_act_o) begin
        dp_write_o <= hwrite_i;
        dp_sel_o   <= hsel_i;
      end
    end
  end
endmodule

// File: rtl/wm_hold.sv
module wm_hold #(
  parameter int unsigned CTRL_W = 16,
  parameter int unsigned DW     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              hready_i,
  input  logic              hresp_i,
  input  logic              addr_act_i,
  input  logic              dp_wr_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [DW-1:0]     wdata_i,
  output logic              viol_ctrl_o,
  output logic              viol_wdata_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [DW-1:0]     wdata_q;
  logic              wait_addr_q, wait_wr_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q      <= '0;
      wdata_q     <= '0;
      wait_addr_q <= 1'b0;
      wait_wr_q   <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      ctrl_q      <= ctrl_i;
      wdata_q     <= wdata_i;
      wait_addr_q <= !hready_i && addr_act_i;
      wait_wr_q   <= !hready_i && dp_wr_i;
      err_q       <= hresp_i;
    end
  end

  // second cycle of an ERROR response may cancel the pending transfer
  assign viol_ctrl_o  = en_i && wait_addr_q && !err_q && (ctrl_i != ctrl_q);
  assign viol_wdata_o = en_i && wait_wr_q && (wdata_i != wdata_q);
endmodule

// File: rtl/wm_stall.sv
module wm_stall #(
  parameter int unsigned HANG_LIMIT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic hready_i,
  output logic viol_o
);
  localparam int unsigned CW = $clog2(HANG_LIMIT + 1);
  localparam logic [CW-1:0] LIMIT_C = CW'(HANG_LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!en_i || hready_i)  cnt_q <= '0;
    else if (cnt_q != LIMIT_C)   cnt_q <= cnt_q + 1'b1;
  end

  // cnt_q counts earlier low cycles of the current run
  assign viol_o = en_i && !hready_i && (cnt_q == LIMIT_C);
endmodule

// File: rtl/wm_flags.sv
module wm_flags #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic [N-1:0] viol_i,
  output logic [N-1:0] err_o,
  output logic         pulse_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      err_o <= '0;
    else if (clear_i) err_o <= '0;
    else              err_o <= err_o | viol_i;
  end

  assign pulse_o = |(viol_i & ~err_o);
endmodule

// File: rtl/ahb_wait_monitor.sv
module ahb_wait_monitor #(
  parameter int unsigned AW         = 32,
  parameter int unsigned DW         = 32,
  parameter int unsigned NSUB       = 4,
  parameter int unsigned HANG_LIMIT = 64
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          clear_i,
  input  logic [1:0]                    htrans_i,
  input  logic [AW-1:0]                 haddr_i,
  input  logic                          hwrite_i,
  input  logic [2:0]                    hsize_i,
  input  logic [2:0]                    hburst_i,
  input  logic [DW-1:0]                 hwdata_i,
  input  logic                          hready_i,
  input  logic                          hresp_i,
  input  logic [NSUB-1:0]               hsel_i,
  input  logic [NSUB-1:0]               resp_sel_i,
  input  logic                          rd_capture_i,
  output logic [wm_pkg::NUM_RULES-1:0]  err_o,
  output logic                          err_pulse_o
);
  import wm_pkg::*;

  localparam int unsigned CTRL_W = 2 + AW + 1 + 3 + 3;

  logic            seen, addr_act, dp_valid, dp_write;
  logic [NSUB-1:0] dp_sel;
  logic            v_hold, v_wdata, v_hang;
  logic [NUM_RULES-1:0] viol;

  wm_pipe #(.NSUB(NSUB)) i_pipe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hready_i   (hready_i),
    .htrans_i   (htrans_i),
    .hwrite_i   (hwrite_i),
    .hsel_i     (hsel_i),
    .seen_o     (seen),
    .addr_act_o (addr_act),
    .dp_valid_o (dp_valid),
    .dp_write_o (dp_write),
    .dp_sel_o   (dp_sel)
  );

  wm_hold #(.CTRL_W(CTRL_W), .DW(DW)) i_hold (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (seen),
    .hready_i     (hready_i),
    .hresp_i      (hresp_i),
    .addr_act_i   (addr_act),
    .dp_wr_i      (dp_valid && dp_write),
    .ctrl_i       ({htrans_i, haddr_i, hwrite_i, hsize_i, hburst_i}),
    .wdata_i      (hwdata_i),
    .viol_ctrl_o  (v_hold),
    .viol_wdata_o (v_wdata)
  );

  wm_stall #(.HANG_LIMIT(HANG_LIMIT)) i_stall (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (seen),
    .hready_i (hready_i),
    .viol_o   (v_hang)
  );

  always_comb begin
    viol             = '0;
    viol[RULE_HOLD]  = v_hold;
    viol[RULE_WDATA] = v_wdata;
    viol[RULE_EARLY] = seen && rd_capture_i && !hready_i && dp_valid && !dp_write;
    viol[RULE_HANG]  = v_hang;
    viol[RULE_SEL]   = seen && dp_valid && hready_i && (resp_sel_i != dp_sel);
  end

  wm_flags #(.N(NUM_RULES)) i_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .viol_i  (viol),
    .err_o   (err_o),
    .pulse_o (err_pulse_o)
  );
endmodule

// File: rtl/wm_checker.sv
module wm_checker (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         clear_i,
  input logic                         hready_i,
  input logic                         rd_capture_i,
  input logic [wm_pkg::NUM_RULES-1:0] err_o,
  input logic                         err_pulse_o
);
  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (err_o == '0));

  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> ((err_o & $past(err_o)) == $past(err_o)));

  assert_pulse_grows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_pulse_o && !clear_i) |=> ($countones(err_o) > $countones($past(err_o))));

  assert_rise_needs_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o != '0 && !$past(clear_i) && ($countones(err_o) > $countones($past(err_o))))
      |-> $past(err_pulse_o));

  assert_hang_after_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o[3]) |-> $past(!hready_i));

  assert_early_needs_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o[2]) |-> $past(rd_capture_i && !hready_i));

  assert_sel_on_complete_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o[4]) |-> $past(hready_i));

  assert_hold_after_wait_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o[0]) |-> !$past(hready_i, 2));
endmodule

bind ahb_wait_monitor wm_checker i_wm_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .clear_i      (clear_i),
  .hready_i     (hready_i),
  .rd_capture_i (rd_capture_i),
  .err_o        (err_o),
  .err_pulse_o  (err_pulse_o)
);

// File: tb/test_ahb_wait_monitor.sv
module test_ahb_wait_monitor;
  localparam int AW = 8, DW = 8, NSUB = 4, LIM = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0, clear_i = 1'b0;
  logic [1:0] htrans_i = 2'b00;
  logic [AW-1:0] haddr_i = '0;
  logic hwrite_i = 1'b0;
  logic [2:0] hsize_i = 3'd2, hburst_i = 3'd0;
  logic [DW-1:0] hwdata_i = '0;
  logic hready_i = 1'b0, hresp_i = 1'b0, rd_capture_i = 1'b0;
  logic [NSUB-1:0] hsel_i = 4'b0001, resp_sel_i = 4'b0001;
  logic [4:0] err_o;
  logic err_pulse_o;

  int checks = 0, errors = 0, pulses = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  ahb_wait_monitor #(.AW(AW), .DW(DW), .NSUB(NSUB), .HANG_LIMIT(LIM)) i_ahb_wait_monitor (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .htrans_i(htrans_i),
    .haddr_i(haddr_i), .hwrite_i(hwrite_i), .hsize_i(hsize_i), .hburst_i(hburst_i),
    .hwdata_i(hwdata_i), .hready_i(hready_i), .hresp_i(hresp_i), .hsel_i(hsel_i),
    .resp_sel_i(resp_sel_i), .rd_capture_i(rd_capture_i), .err_o(err_o),
    .err_pulse_o(err_pulse_o)
  );

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    #1;
    if (err_pulse_o) pulses++;
    @(posedge clk_i); #1;
  endtask

  task automatic set_idle();
    htrans_i = 2'b00; hready_i = 1'b1; hresp_i = 1'b0; rd_capture_i = 1'b0;
    hwrite_i = 1'b0; hsize_i = 3'd2; hburst_i = 3'd0;
    hsel_i = 4'b0001; resp_sel_i = 4'b0001;
  endtask

  task automatic fresh();
    set_idle(); clear_i = 1'b1; tick(); clear_i = 1'b0; pulses = 0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary(); $finish;
    end
  end

  initial begin
    htrans_i = 2'b10;
    repeat (3) @(posedge clk_i);
    #1;
    check(err_o, 0, "R8 reset value");
    rst_ni = 1'b1;
    // R7: long stall and moving address before first ready-high cycle
    for (int i = 0; i < LIM + 4; i++) begin
      htrans_i = 2'b10; hready_i = 1'b0; haddr_i = 8'(i); tick();
    end
    set_idle(); tick();
    check(err_o, 0, "R7 no check before armed");
    check(pulses, 0, "R7 no pulse before armed");

    // R5: stall length sweep
    for (int len = 1; len <= LIM + 4; len++) begin
      fresh();
      for (int k = 0; k < len; k++) begin hready_i = 1'b0; tick(); end
      hready_i = 1'b1; tick();
      check(err_o, (len > LIM) ? 5'b01000 : 0, $sformatf("R5 stall len %0d", len));
      check(pulses, (len > LIM) ? 1 : 0, $sformatf("R9 hang pulses len %0d", len));
    end

    // R1: hold sweep over address bits and control fields
    for (int m = 0; m <= AW + 4; m++) begin
      fresh();
      htrans_i = 2'b10; haddr_i = 8'h30; tick();          // A accepted (read)
      haddr_i = 8'hA5; hready_i = 1'b0; tick();            // B pending, wait
      if (m >= 1 && m <= AW) haddr_i = haddr_i ^ 8'(1 << (m - 1));
      if (m == AW + 1) hwrite_i = 1'b1;
      if (m == AW + 2) hsize_i = hsize_i ^ 3'd1;
      if (m == AW + 3) hburst_i = hburst_i ^ 3'd1;
      if (m == AW + 4) htrans_i = 2'b11;
      tick();                                              // still waiting
      hready_i = 1'b1; tick();                             // B accepted
      set_idle(); tick();
      check(err_o, (m != 0) ? 5'b00001 : 0, $sformatf("R1 hold mod %0d", m));
      check(pulses, (m != 0) ? 1 : 0, $sformatf("R9 hold pulses mod %0d", m));
    end

    // R2: ERROR response second cycle may cancel to IDLE
    fresh();
    htrans_i = 2'b10; haddr_i = 8'h10; tick();
    haddr_i = 8'h20; hready_i = 1'b0; tick();
    hresp_i = 1'b1; tick();                                // error, first cycle
    htrans_i = 2'b00; haddr_i = 8'h77; hready_i = 1'b1; tick();
    set_idle(); tick();
    check(err_o, 0, "R2 error cancel exempt");

    // R3: write-data hold sweep, writes and reads
    for (int w = 0; w < 2; w++) begin
      for (int b = -1; b < DW; b++) begin
        fresh();
        htrans_i = 2'b10; hwrite_i = w[0]; tick();
        htrans_i = 2'b00; hready_i = 1'b0; hwdata_i = 8'h5A; tick();
        if (b >= 0) hwdata_i = hwdata_i ^ 8'(1 << b);
        tick();
        hready_i = 1'b1; tick();
        set_idle(); tick();
        check(err_o, (w == 1 && b >= 0) ? 5'b00010 : 0,
              $sformatf("R3 wdata write=%0d bit=%0d", w, b));
      end
    end

    // R4: capture strobe sweep
    for (int kind = 0; kind < 3; kind++)
      for (int rdy = 0; rdy < 2; rdy++)
        for (int cap = 0; cap < 2; cap++) begin
          fresh();
          if (kind > 0) begin htrans_i = 2'b10; hwrite_i = (kind == 2); tick(); end
          htrans_i = 2'b00; hready_i = rdy[0]; rd_capture_i = cap[0]; tick();
          if (rdy == 0) begin rd_capture_i = 1'b0; hready_i = 1'b1; tick(); end
          set_idle(); tick();
          check(err_o, (kind == 1 && rdy == 0 && cap == 1) ? 5'b00100 : 0,
                $sformatf("R4 kind=%0d rdy=%0d cap=%0d", kind, rdy, cap));
        end

    // R6: all address-phase / response select pairings
    for (int a = 0; a < NSUB; a++)
      for (int r = 0; r < NSUB; r++) begin
        fresh();
        htrans_i = 2'b10; hsel_i = 4'(1 << a); resp_sel_i = 4'b0000; tick();
        htrans_i = 2'b00; hsel_i = 4'(1 << ((a + 1) % NSUB));
        resp_sel_i = 4'(1 << ((a + 2) % NSUB)); hready_i = 1'b0; tick();
        resp_sel_i = 4'(1 << r); hready_i = 1'b1; tick();
        resp_sel_i = 4'b0000; tick();
        check(err_o, (a != r) ? 5'b10000 : 0, $sformatf("R6 sel a=%0d r=%0d", a, r));
      end

    // R8/R9: sticky, no repeat pulse, pulse on a new rule, clear
    fresh();
    htrans_i = 2'b10; hsel_i = 4'b0001; tick();
    htrans_i = 2'b00; resp_sel_i = 4'b0010; tick();
    set_idle(); repeat (3) tick();
    check(err_o, 5'b10000, "R8 sticky after violation");
    check(pulses, 1, "R9 first select pulse");
    htrans_i = 2'b10; hsel_i = 4'b0001; tick();
    htrans_i = 2'b00; resp_sel_i = 4'b0100; tick();
    set_idle(); tick();
    check(pulses, 1, "R9 no pulse on repeated rule");
    htrans_i = 2'b10; tick();
    htrans_i = 2'b00; hready_i = 1'b0; rd_capture_i = 1'b1; tick();
    rd_capture_i = 1'b0; hready_i = 1'b1; tick();
    check(pulses, 2, "R9 pulse on new rule");
    check(err_o, 5'b10100, "R8 both bits held");
    // clear wins over a simultaneous violation
    htrans_i = 2'b10; tick();
    htrans_i = 2'b00; resp_sel_i = 4'b1000; clear_i = 1'b1; tick();
    clear_i = 1'b0; set_idle(); #1;
    check(err_o, 0, "R8 clear priority");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule